// File: doc/BRIEF.md
# Reloadable Interval Timer with Waveform Output

This block is a down-counting timer for a peripheral interface device, programmed over a small 8-bit register bus. A 16-bit counter steps down once per cycle in which the system clock enable is high. A separate 16-bit reload register holds the period. When the counter passes zero, an interrupt flag is set. In single-shot mode this happens once per start. In continuous mode the counter reloads by itself from the reload register and keeps counting without any help from software.

The reload register can be changed while the counter runs, and the new value is taken only at the next reload, so software can change the period without a glitch. In single-shot mode the counter keeps stepping down after it expires, so the time since expiry can be read back. An optional waveform pin gives one low-going pulse in single-shot mode, or a square wave that toggles at every expiry in continuous mode.

Register map (3-bit address, 8-bit data). Address 0: a write sets the low reload byte; a read returns the low count byte and, when the read strobe is high, clears the flag. Address 1: a write sets the high reload byte and starts the timer; a read returns the high count byte. Address 2 and address 3: the low and high reload bytes, written and read back with no side effect. Address 4: control, where bit 0 selects continuous mode (1) or single-shot mode (0) and bit 1 enables the waveform pin. Address 5: bit 0 reads the flag, and writing 1 to bit 0 clears the flag. Read data is combinational on the address and does not depend on the select input.

Top module: `reload_timer`

## Requirements
- R1: After reset, the count, the reload value, the control bits and the flag are all zero, `irq` is low and `wave_out` is high.
- R2: Writes to address 2 or address 3 change only the reload value; the running count is left unchanged.
- R3: A write to address 1 loads the count with {written byte, low reload byte}, stores the byte as the high reload byte, clears the flag, arms single-shot mode and drives the internal wave level low.
- R4: The count goes down by exactly one in each cycle with `tick_en` high and holds in every other cycle, unless a start or a reload applies.
- R5: In single-shot mode, a tick taken at count 0 sets the flag once and the count moves on to 0xFFFF. No later pass through zero sets the flag until the next start.
- R6: In continuous mode, a tick taken at count 0 sets the flag and the count goes to 0xFFFF. The next tick loads the reload value, so one period is the reload value plus 2 ticks.
- R7: A reload value written while the counter runs is used at the next reload in continuous mode.
- R8: The flag is cleared by a read of address 0 with `rd` high, or by writing 1 to bit 0 of address 5. Writing 0 there has no effect.
- R9: When an expiry and a flag clear fall in the same cycle, the flag ends up set.
- R10: `wave_out` is high while control bit 1 is 0. When bit 1 is 1, `wave_out` shows the wave level: low after a start, high at the expiry in single-shot mode, and inverted at each expiry in continuous mode.
- R11: A start that falls in the same cycle as a tick takes precedence: the count takes the start value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe, qualified by `sel` |
| rd | input | 1 | Read strobe, qualified by `sel`; only address 0 has a side effect |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on `addr` |
| irq | output | 1 | Interrupt flag level |
| wave_out | output | 1 | Waveform pin |

## Verification
Two events can land on the flag in the same cycle: an expiry that sets it and a software clear from the count-low read. The bench counts the timer down to zero in continuous mode. It then raises `tick_en` and a strobed read of address 0 in the same cycle. The read must return the zero count, and afterwards `irq` must still be high. A separate clear, made one cycle later, must then bring it low. The same approach is used to put a start and a tick in one cycle; there the count must equal the start value, not one less.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_LAT_LO = 3'd2,
    A_LAT_HI = 3'd3,
    A_CTRL   = 3'd4,
    A_FLAG   = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic out_en;
    logic free_run;
  } ctrl_t;

endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             flag_q,
  output logic [CNT_W-1:0] latch_q,
  output ctrl_t            ctrl_q,
  output logic             start,
  output logic [CNT_W-1:0] start_val,
  output logic             clr_req,
  output logic [BUS_W-1:0] rdata
);

  logic [CNT_W-1:0] latch_d;
  ctrl_t            ctrl_d;
  logic             wen;
  logic             wr_lo;
  logic             wr_hi;
  logic             unused_wbits;

  assign wen   = sel & wr;
  assign wr_lo = wen & ((addr == A_CNT_LO) | (addr == A_LAT_LO));
  assign wr_hi = wen & ((addr == A_CNT_HI) | (addr == A_LAT_HI));
  assign start = wen & (addr == A_CNT_HI);
  assign start_val = {wdata, latch_q[BUS_W-1:0]};
  assign clr_req = (sel & rd & (addr == A_CNT_LO)) |
                   (wen & (addr == A_FLAG) & wdata[0]);
  assign unused_wbits = ^wdata[BUS_W-1:2];

  always_comb begin
    latch_d = latch_q;
    if (wr_lo) latch_d[BUS_W-1:0] = wdata;
    if (wr_hi) latch_d[CNT_W-1:BUS_W] = wdata;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wen && (addr == A_CTRL)) ctrl_d = ctrl_t'(wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      ctrl_q  <= '0;
    end else begin
      latch_q <= latch_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt_q[BUS_W-1:0];
      A_CNT_HI: rdata = cnt_q[CNT_W-1:BUS_W];
      A_LAT_LO: rdata = latch_q[BUS_W-1:0];
      A_LAT_HI: rdata = latch_q[CNT_W-1:BUS_W];
      A_CTRL:   rdata = {{(BUS_W-2){1'b0}}, ctrl_q};
      A_FLAG:   rdata = {{(BUS_W-1){1'b0}}, flag_q};
      default:  rdata = '0;
    endcase
  end

  // R2: latch-only addresses never start the counter
  assert_latch_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && (addr == A_LAT_LO || addr == A_LAT_HI)) |-> !start);

endmodule

// File: rtl/timer_core.sv
module timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             free_run,
  input  logic [CNT_W-1:0] latch_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_d;
  logic             wrap_q, wrap_d;
  logic             armed_q, armed_d;
  logic             at_zero;
  logic             zero_tick;

  assign at_zero   = (cnt_q == '0);
  assign zero_tick = tick & ~start & at_zero;
  assign expire    = zero_tick & (free_run | armed_q);

  always_comb begin
    cnt_d   = cnt_q;
    wrap_d  = wrap_q;
    armed_d = armed_q;
    if (start) begin
      cnt_d   = start_val;
      wrap_d  = 1'b0;
      armed_d = 1'b1;
    end else if (tick) begin
      if (wrap_q && free_run) cnt_d = latch_q;
      else                    cnt_d = cnt_q - 1'b1;
      wrap_d = at_zero;
      if (at_zero && !free_run) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      wrap_q  <= wrap_d;
      armed_q <= armed_d;
    end
  end

  assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(start_val)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !tick) |=> (cnt_q == $past(cnt_q)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && !(wrap_q && free_run)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && wrap_q && free_run) |=> (cnt_q == $past(latch_q)));

  assert_start_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && tick) |=> (cnt_q == $past(start_val)));

endmodule

// File: rtl/timer_flag_wave.sv
module timer_flag_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic free_run,
  input  logic out_en,
  input  logic start,
  input  logic clr_req,
  output logic irq,
  output logic wave_out
);

  logic flag_q, flag_d;
  logic wave_q, wave_d;

  always_comb begin
    flag_d = flag_q;
    if (expire)                flag_d = 1'b1;
    else if (start || clr_req) flag_d = 1'b0;
  end

  always_comb begin
    wave_d = wave_q;
    if (start)       wave_d = 1'b0;
    else if (expire) wave_d = free_run ? ~wave_q : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      wave_q <= 1'b1;
    end else begin
      flag_q <= flag_d;
      wave_q <= wave_d;
    end
  end

  assign irq      = flag_q;
  assign wave_out = out_en ? wave_q : 1'b1;

  assert_rise_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !flag_q);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  assert_start_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !wave_q);

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             irq,
  output logic             wave_out
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_val;
  ctrl_t            ctrl_q;
  logic             start;
  logic             clr_req;
  logic             expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  timer_regs #(.BUS_W(BUS_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel       (sel),
    .wr        (wr),
    .rd        (rd),
    .addr      (addr),
    .wdata     (wdata),
    .cnt_q     (cnt_q),
    .flag_q    (irq),
    .latch_q   (latch_q),
    .ctrl_q    (ctrl_q),
    .start     (start),
    .start_val (start_val),
    .clr_req   (clr_req),
    .rdata     (rdata)
  );

  timer_core #(.CNT_W(CNT_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick_en),
    .start     (start),
    .start_val (start_val),
    .free_run  (ctrl_q.free_run),
    .latch_q   (latch_q),
    .cnt_q     (cnt_q),
    .expire    (expire)
  );

  timer_flag_wave flag_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .expire   (expire),
    .free_run (ctrl_q.free_run),
    .out_en   (ctrl_q.out_en),
    .start    (start),
    .clr_req  (clr_req),
    .irq      (irq),
    .wave_out (wave_out)
  );

  // R10: a disabled waveform pin idles high
  assert_idle_pin_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctrl_q.out_en |-> wave_out);

endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       sel = 1'b0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  logic       wave_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wave_out(wave_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d; tick_en = 1;
    @(negedge clk);
    sel = 0; wr = 0; tick_en = 0;
  endtask

  task automatic rd_strobe(input logic [2:0] a, input bit with_tick, output logic [7:0] d);
    @(negedge clk);
    sel = 1; rd = 1; addr = a; tick_en = with_tick;
    #1 d = rdata;
    @(negedge clk);
    sel = 0; rd = 0; tick_en = 0;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic peek_cnt(output int c);
    logic [7:0] lo, hi;
    peek(3'd0, lo);
    peek(3'd1, hi);
    c = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    int c;
    peek_cnt(c);          chk("R1 count", c, 0);
    peek(3'd2, d);        chk("R1 reload lo", d, 0);
    peek(3'd3, d);        chk("R1 reload hi", d, 0);
    peek(3'd4, d);        chk("R1 ctrl", d, 0);
    peek(3'd5, d);        chk("R1 flag reg", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wave_out", wave_out, 1);
  endtask

  task automatic t_oneshot;
    int c;
    bus_write(3'd2, 8'd5);
    bus_write(3'd4, 8'h02);
    bus_write(3'd1, 8'h00);
    peek_cnt(c);          chk("R3 start count", c, 5);
    chk("R10 pulse low after start", wave_out, 0);
    repeat (3) @(negedge clk);
    peek_cnt(c);          chk("R4 hold without tick", c, 5);
    tick_n(5);
    peek_cnt(c);          chk("R4 five ticks", c, 0);
    chk("R5 no irq before zero tick", irq, 0);
    tick_n(1);
    peek_cnt(c);          chk("R5 past zero", c, 16'hFFFF);
    chk("R5 irq set", irq, 1);
    chk("R10 pulse high at expiry", wave_out, 1);
    bus_write(3'd5, 8'h00);
    chk("R8 write 0 keeps flag", irq, 1);
    bus_write(3'd5, 8'h01);
    chk("R8 write 1 clears flag", irq, 0);
    tick_n(65535);
    peek_cnt(c);          chk("R5 counted round to zero", c, 0);
    tick_n(1);
    peek_cnt(c);          chk("R5 second pass wraps", c, 16'hFFFF);
    chk("R5 no second irq", irq, 0);
    chk("R10 pulse stays high", wave_out, 1);
  endtask

  task automatic t_restart_and_collide_start;
    logic [7:0] d;
    int c;
    bus_write(3'd2, 8'd2);
    bus_write(3'd1, 8'h00);
    tick_n(3);
    chk("R5 irq after restart expiry", irq, 1);
    bus_write(3'd1, 8'h00);
    chk("R3 start clears flag", irq, 0);
    peek_cnt(c);          chk("R3 reloaded count", c, 2);
    chk("R3 wave low", wave_out, 0);
    bus_write(3'd2, 8'd7);
    bus_write(3'd3, 8'h12);
    peek_cnt(c);          chk("R2 count untouched", c, 2);
    peek(3'd3, d);        chk("R2 reload hi readback", d, 8'h12);
    peek(3'd2, d);        chk("R2 reload lo readback", d, 8'd7);
    wr_tick(3'd1, 8'h00);
    peek_cnt(c);          chk("R11 start beats tick", c, 7);
  endtask

  task automatic t_freerun;
    logic [7:0] d;
    int c;
    bus_write(3'd2, 8'd3);
    bus_write(3'd4, 8'h03);
    bus_write(3'd1, 8'h00);
    peek_cnt(c);          chk("R3 free-run start", c, 3);
    chk("R10 free-run wave low", wave_out, 0);
    tick_n(3);
    peek_cnt(c);          chk("R6 at zero", c, 0);
    chk("R6 no irq yet", irq, 0);
    tick_n(1);
    peek_cnt(c);          chk("R6 through 0xFFFF", c, 16'hFFFF);
    chk("R6 irq set", irq, 1);
    chk("R10 toggled high", wave_out, 1);
    rd_strobe(3'd0, 1'b0, d);
    chk("R8 read value", d, 8'hFF);
    chk("R8 read clears flag", irq, 0);
    tick_n(1);
    peek_cnt(c);          chk("R6 reload taken", c, 3);
    bus_write(3'd2, 8'd7);
    peek_cnt(c);          chk("R7 running count kept", c, 3);
    tick_n(4);
    peek_cnt(c);          chk("R7 wraps old period", c, 16'hFFFF);
    chk("R10 toggled low", wave_out, 0);
    tick_n(1);
    peek_cnt(c);          chk("R7 new period loaded", c, 7);
    bus_write(3'd4, 8'h01);
    chk("R10 disabled pin idles high", wave_out, 1);
  endtask

  task automatic t_set_clear_collide;
    logic [7:0] d;
    int c;
    bus_write(3'd2, 8'd1);
    bus_write(3'd1, 8'h00);
    tick_n(1);
    bus_write(3'd5, 8'h01);
    peek_cnt(c);          chk("R9 at zero", c, 0);
    rd_strobe(3'd0, 1'b1, d);
    chk("R9 read saw zero", d, 0);
    chk("R9 set wins", irq, 1);
    rd_strobe(3'd0, 1'b0, d);
    chk("R8 later clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_oneshot();
    t_restart_and_collide_start();
    t_freerun();
    t_set_clear_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule